// File: doc/BRIEF.md
# DRAM Initialization Address Override

This block lets a host hold the SDRAM row-address and bank-address lines at a pattern of its own choosing while the DRAM's mode registers are being programmed. It sits next to the host's memory controller. The host reaches it through a byte-wide I/O port, and the block answers to a fixed window of eight consecutive port addresses starting at `BASE_ADDR` (0xAC10 by default).

Out of reset the block drives the address and bank lines from its pattern registers. It also holds its switch-enable output low, which keeps the external bus switches open so the controller side is cut off. The host writes a pattern and issues the DRAM command. When initialization is finished, the host sets a single control bit. That bit closes the switches and puts the block's address and bank drivers into high impedance, so the controller alone owns the lines.

The block's reset comes from the DRAM clock-enable line. Whenever that line is low, all state returns to its default on the next clock edge.

Top module: `init_addr_override`

## Requirements
- R1: While `dram_cke` is low at a clock edge, both pattern registers clear to 0x00. After that edge `sw_close` is 0, `row_addr` drives 0 and `bank_addr` drives 0.
- R2: A write to offset 0 (port 0xAC10) stores the data byte as row bits 7:0. The new value appears on `row_addr[7:0]` after the first clock edge that samples `io_wr`.
- R3: A write to offset 1 (port 0xAC11) stores row bits 12:8 from data bits 4:0 and bank bits 1:0 from data bits 6:5. Both appear on the outputs after the sampling edge.
- R4: Data bit 7 of the offset-1 register is the release bit. While it is 1, `sw_close` is 1 and both `row_addr` and `bank_addr` are high impedance, so another driver on those nets sets their value.
- R5: Writing 0 to the release bit makes `sw_close` 0 again, and the stored pattern is driven again after the next edge.
- R6: `io_claim` is 1 exactly when `io_addr` lies within 0xAC10–0xAC17. Otherwise it is 0.
- R7: A read of offset 0 or offset 1 returns the stored byte on `io_rdata`, valid after the clock edge that samples `io_rd`. For offset 1 the byte includes the release bit.
- R8: A read of offsets 2–7 returns 0x00. Writes to offsets 2–7 change no register.
- R9: Writes to addresses outside the window change no register.
- R10: Pulling `dram_cke` low after the lines have been released clears the release bit and the pattern. The block then drives 0x000 on the row lines again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| dram_cke | input | 1 | DRAM clock enable; low acts as reset |
| io_addr | input | 16 | Host I/O port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| io_claim | output | 1 | Address falls in the block's window |
| row_addr | output | 13 | Row-address override, high-Z when released |
| bank_addr | output | 2 | Bank-address override, high-Z when released |
| sw_close | output | 1 | 1 closes the bus switches (controller drives) |

## Verification
The key internal state is the two pattern registers. A bit that is wrong in either one shows up on `row_addr`, `bank_addr` or `sw_close` right after the edge that stored it, and shows up on a readback one edge after the read strobe. A release bit that is stuck, or one that lost its reset, is the most serious fault: it either leaves the block fighting the controller on the shared nets or never hands the lines over. The bench therefore drives the shared nets from a second source once the switch is closed and compares the value that results. A fault in the window decode shows up at once on `io_claim`, or as an unexpected change to the pattern one edge after a write from outside the window.

// File: rtl/init_ovr_pkg.sv
package init_ovr_pkg;
  localparam int unsigned ROW_W    = 13;
  localparam int unsigned BANK_W   = 2;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LO_BITS  = BYTE_W;
  localparam int unsigned HI_BITS  = ROW_W - LO_BITS;
  localparam int unsigned BANK_LSB = HI_BITS;
  localparam int unsigned CLOSE_BIT = BANK_LSB + BANK_W;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_ZERO = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ovr_window_decode.sv
module ovr_window_decode
  import init_ovr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BITS  = 3,
  parameter logic [15:0] BASE_ADDR = 16'hAC10
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              claim,
  output reg_sel_e          sel
);
  localparam int unsigned TAG_W = ADDR_W - WIN_BITS;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:WIN_BITS];

  logic [WIN_BITS-1:0] offset;

  always_comb begin
    offset = addr[WIN_BITS-1:0];
    claim  = (addr[ADDR_W-1:WIN_BITS] == BASE_TAG);
    if (!claim)                           sel = SEL_NONE;
    else if (offset == WIN_BITS'(0))      sel = SEL_LO;
    else if (offset == WIN_BITS'(1))      sel = SEL_HI;
    else                                  sel = SEL_ZERO;
  end
endmodule

// File: rtl/ovr_pattern_regs.sv
module ovr_pattern_regs
  import init_ovr_pkg::*;
(
  input  logic              clk,
  input  logic              dram_cke,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q
);
  always_ff @(posedge clk) begin
    if (!dram_cke) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr) begin
      if (sel == SEL_LO) lo_q <= wdata;
      if (sel == SEL_HI) hi_q <= wdata;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    !dram_cke |=> (lo_q == '0 && hi_q == '0));

  assert_low_write_R2: assert property (@(posedge clk) disable iff (!dram_cke)
    (wr && sel == SEL_LO) |=> (lo_q == $past(wdata)));

  assert_high_write_R3: assert property (@(posedge clk) disable iff (!dram_cke)
    (wr && sel == SEL_HI) |=> (hi_q == $past(wdata)));

  assert_ignore_other_R8: assert property (@(posedge clk) disable iff (!dram_cke)
    (wr && (sel == SEL_ZERO || sel == SEL_NONE)) |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/ovr_readback.sv
module ovr_readback
  import init_ovr_pkg::*;
(
  input  logic              clk,
  input  logic              dram_cke,
  input  logic              rd,
  input  reg_sel_e          sel,
  input  logic [BYTE_W-1:0] lo_q,
  input  logic [BYTE_W-1:0] hi_q,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] rd_mux;

  always_comb begin
    unique case (sel)
      SEL_LO:  rd_mux = lo_q;
      SEL_HI:  rd_mux = hi_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!dram_cke)  rdata <= '0;
    else if (rd)    rdata <= rd_mux;
  end

  assert_zero_offsets_R8: assert property (@(posedge clk) disable iff (!dram_cke)
    (rd && sel == SEL_ZERO) |=> (rdata == '0));

  assert_readback_R7: assert property (@(posedge clk) disable iff (!dram_cke)
    (rd && sel == SEL_HI) |=> (rdata == $past(hi_q)));
endmodule

// File: rtl/ovr_pin_drive.sv
module ovr_pin_drive
  import init_ovr_pkg::*;
(
  input  logic              clk,
  input  logic              dram_cke,
  input  logic [BYTE_W-1:0] lo_q,
  input  logic [BYTE_W-1:0] hi_q,
  output logic [ROW_W-1:0]  row_addr,
  output logic [BANK_W-1:0] bank_addr,
  output logic              sw_close
);
  logic [ROW_W-1:0]  row_pat;
  logic [BANK_W-1:0] bank_pat;

  always_comb begin
    row_pat  = {hi_q[HI_BITS-1:0], lo_q};
    bank_pat = hi_q[BANK_LSB +: BANK_W];
    sw_close = hi_q[CLOSE_BIT];
  end

  assign row_addr  = sw_close ? {ROW_W{1'bz}}  : row_pat;
  assign bank_addr = sw_close ? {BANK_W{1'bz}} : bank_pat;

  assert_open_after_reset_R10: assert property (@(posedge clk)
    !dram_cke |=> !sw_close);
endmodule

// File: rtl/init_addr_override.sv
module init_addr_override
  import init_ovr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BITS  = 3,
  parameter logic [15:0] BASE_ADDR = 16'hAC10
) (
  input  logic              clk,
  input  logic              dram_cke,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_claim,
  output logic [12:0]       row_addr,
  output logic [1:0]        bank_addr,
  output logic              sw_close
);
  reg_sel_e          sel;
  logic [BYTE_W-1:0] lo_q;
  logic [BYTE_W-1:0] hi_q;

  ovr_window_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .addr(io_addr), .claim(io_claim), .sel(sel)
  );

  ovr_pattern_regs u_regs (
    .clk(clk), .dram_cke(dram_cke), .wr(io_wr), .sel(sel),
    .wdata(io_wdata), .lo_q(lo_q), .hi_q(hi_q)
  );

  ovr_readback u_rd (
    .clk(clk), .dram_cke(dram_cke), .rd(io_rd), .sel(sel),
    .lo_q(lo_q), .hi_q(hi_q), .rdata(io_rdata)
  );

  ovr_pin_drive u_pins (
    .clk(clk), .dram_cke(dram_cke), .lo_q(lo_q), .hi_q(hi_q),
    .row_addr(row_addr), .bank_addr(bank_addr), .sw_close(sw_close)
  );

  assert_release_follows_write_R4: assert property (@(posedge clk) disable iff (!dram_cke)
    (io_wr && sel == SEL_HI) |=> (sw_close == $past(io_wdata[7])));
endmodule

// File: tb/tb_init_addr_override.sv
module tb_init_addr_override;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        dram_cke = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_claim;
  wire  [12:0] row_bus;
  wire  [1:0]  bank_bus;
  logic        sw_close;

  logic        proc_drive = 1'b0;
  logic [12:0] proc_row = '0;
  logic [1:0]  proc_bank = '0;

  assign row_bus  = proc_drive ? proc_row  : 13'bz;
  assign bank_bus = proc_drive ? proc_bank : 2'bz;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  init_addr_override dut (
    .clk(clk), .dram_cke(dram_cke), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_claim(io_claim), .row_addr(row_bus), .bank_addr(bank_bus),
    .sw_close(sw_close)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_port(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_port(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); dram_cke = 1'b0;
    @(negedge clk); @(negedge clk);
    dram_cke = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    do_reset();
    chk("R1 sw_close", {15'd0, sw_close}, 16'd0);
    chk("R1 row", {3'd0, row_bus}, 16'd0);
    chk("R1 bank", {14'd0, bank_bus}, 16'd0);
    rd_port(16'hAC11, d);
    chk("R1 hi reg", {8'd0, d}, 16'd0);
  endtask

  task automatic t_low_byte();
    logic [7:0] d;
    @(negedge clk); io_addr = 16'hAC10; io_wdata = 8'hA5; io_wr = 1'b1;
    chk("R2 before edge", {3'd0, row_bus}, 16'd0);
    @(negedge clk); io_wr = 1'b0;
    chk("R2 row low", {3'd0, row_bus}, 16'h00A5);
    rd_port(16'hAC10, d);
    chk("R7 read lo", {8'd0, d}, 16'h00A5);
  endtask

  task automatic t_high_byte();
    logic [7:0] d;
    wr_port(16'hAC11, 8'b0_10_10110);
    chk("R3 row", {3'd0, row_bus}, {3'd0, 5'b10110, 8'hA5});
    chk("R3 bank", {14'd0, bank_bus}, 16'd2);
    chk("R3 sw_close", {15'd0, sw_close}, 16'd0);
    rd_port(16'hAC11, d);
    chk("R7 read hi", {8'd0, d}, 16'h0056);
  endtask

  task automatic t_window();
    io_addr = 16'hAC0F; #1; chk("R6 below", {15'd0, io_claim}, 16'd0);
    io_addr = 16'hAC10; #1; chk("R6 first", {15'd0, io_claim}, 16'd1);
    io_addr = 16'hAC17; #1; chk("R6 last", {15'd0, io_claim}, 16'd1);
    io_addr = 16'hAC18; #1; chk("R6 above", {15'd0, io_claim}, 16'd0);
    io_addr = 16'h2C10; #1; chk("R6 alias", {15'd0, io_claim}, 16'd0);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    for (int off = 2; off < 8; off++) begin
      wr_port(16'hAC10 + 16'(off), 8'hFF);
      rd_port(16'hAC10 + 16'(off), d);
      chk("R8 zero read", {8'd0, d}, 16'd0);
    end
    chk("R8 row unchanged", {3'd0, row_bus}, {3'd0, 5'b10110, 8'hA5});
    chk("R8 bank unchanged", {14'd0, bank_bus}, 16'd2);
    wr_port(16'hAC00, 8'hFF);
    wr_port(16'hAD11, 8'hFF);
    wr_port(16'h2C10, 8'h00);
    chk("R9 row unchanged", {3'd0, row_bus}, {3'd0, 5'b10110, 8'hA5});
    chk("R9 sw_close", {15'd0, sw_close}, 16'd0);
  endtask

  task automatic t_release();
    logic [7:0] d;
    wr_port(16'hAC11, 8'b1_01_00011);
    chk("R4 sw_close", {15'd0, sw_close}, 16'd1);
    proc_row = 13'h0C5A; proc_bank = 2'b10; proc_drive = 1'b1;
    #1;
    chk("R4 row from processor", {3'd0, row_bus}, 16'h0C5A);
    chk("R4 bank from processor", {14'd0, bank_bus}, 16'd2);
    rd_port(16'hAC11, d);
    chk("R7 read release", {8'd0, d}, 16'h00A3);
    proc_drive = 1'b0;
    wr_port(16'hAC11, 8'b0_01_00011);
    chk("R5 sw_close", {15'd0, sw_close}, 16'd0);
    chk("R5 row back", {3'd0, row_bus}, {3'd0, 5'b00011, 8'hA5});
    chk("R5 bank back", {14'd0, bank_bus}, 16'd1);
  endtask

  task automatic t_cke_drop();
    wr_port(16'hAC11, 8'hFF);
    chk("R10 released", {15'd0, sw_close}, 16'd1);
    do_reset();
    chk("R10 sw_close", {15'd0, sw_close}, 16'd0);
    chk("R10 row", {3'd0, row_bus}, 16'd0);
    chk("R10 bank", {14'd0, bank_bus}, 16'd0);
  endtask

  initial begin
    t_reset_state();
    t_low_byte();
    t_high_byte();
    t_window();
    t_ignored();
    t_release();
    t_cke_drop();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule